// File: doc/BRIEF.md
# Unfolded Parallel Nine-Tap Feedback Recursive Filter

This block evaluates the recursion y(n) = a·y(n−9) + x(n) on a stream of signed fixed-point samples. It takes in `LANES` consecutive samples per clock and returns the same number of filtered samples per clock. The single nine-sample feedback loop is spread across the lanes. Lane j reads the output of one other lane, taken from a short per-lane history register chain. The depths of those chains add up to exactly nine. The default is two lanes, which halves the clock rate needed for a given sample rate.

Samples and coefficient are 16-bit two's-complement values with 15 fraction bits. Each lane multiplies the delayed output by the coefficient and truncates the product back to 15 fraction bits by dropping the low bits (flooring). It then adds the lane's input sample with wrap-around arithmetic. The multiply-add is combinational and feeds a registered output beat.

Both the input and output sides use valid/ready handshakes. A beat is taken on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. While the output holds a beat that the consumer has not taken, the block accepts nothing, and the held beat stays unchanged. The coefficient is intended to stay constant while the block runs. Keeping a stream aligned to multiples of `LANES` samples is the user's job.

Top module: `iir_unf_top`

## Requirements
- R1: While `rst_n` is low and in the cycle after it rises, `out_valid` is 0 and every feedback history register is cleared to zero.
- R2: Lane j of `in_data` and `out_data` occupies bits [16j+15:16j] and carries sample `LANES`·k + j of beat k. Lane 0 holds the earliest sample.
- R3: Every output sample equals trunc15(a·y(n−9)) + x(n), where trunc15 keeps bits [30:15] of the 32-bit signed product. The sum wraps modulo 2^16.
- R4: The first nine samples after reset see a zero history, so each output equals its input sample.
- R5: One clock after an accepted beat, `out_valid` is 1 and `out_data` carries that beat's results. After a cycle with no new beat and `out_ready` high, `out_valid` is 0.
- R6: While `out_valid` is 1 and `out_ready` is 0, `out_valid` and `out_data` hold their values on the next clock.
- R7: `in_ready` is 1 exactly when `out_valid` is 0 or `out_ready` is 1. A beat is taken only when `in_valid` and `in_ready` are both 1.
- R8: Cycles in which no beat is taken leave the feedback history unchanged. Bubbles and stalls therefore do not alter any later output value.
- R9: `LANES` may range from 1 to 9. Lane i feeds lane (i+9) mod `LANES` through floor((i+9)/`LANES`) history registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| coeff | input | 16 | Feedback coefficient a, signed, 15 fraction bits |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Block can take an input beat |
| in_data | input | 16·LANES | LANES input samples, lane 0 in the low bits |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Consumer takes the output beat |
| out_data | output | 16·LANES | LANES output samples, lane 0 in the low bits |

## Verification
The bench targets four failure modes.

- Cross-lane wiring: a design that swaps the source lane or miscounts the history depth of one lane gives correct values for the first nine samples. It then drifts from the sample-serial model as soon as feedback begins.
- Truncation and wrap: a design that rounds the product, takes the wrong bit slice, or saturates shows up under a near-unity coefficient with large inputs. That stimulus forces both the product and the sum past full scale.
- Bubbles: a design that advances the history during bubbles produces results shifted by whole beats.
- Stalls: a design that drops or overwrites a stalled beat shows changed output data, or an `in_ready` that stays high, while the consumer holds `out_ready` low.

// File: rtl/iir_unf_pkg.sv
package iir_unf_pkg;

  // Lane whose output feeds lane dst across a loop of loop_delay samples.
  function automatic int src_lane(input int dst, input int lanes, input int loop_delay);
    return (dst + lanes * loop_delay - loop_delay) % lanes;
  endfunction

  // History stages on the edge that leaves lane src.
  function automatic int tap_depth(input int src, input int lanes, input int loop_delay);
    return (src + loop_delay) / lanes;
  endfunction

  // Lane that receives the output of lane src.
  function automatic int dst_lane(input int src, input int lanes, input int loop_delay);
    return (src + loop_delay) % lanes;
  endfunction

endpackage

// File: rtl/iir_unf_tap.sv
module iir_unf_tap #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stage [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < DEPTH; s++) stage[s] <= '0;
    end else if (shift) begin
      stage[0] <= din;
      for (int s = 1; s < DEPTH; s++) stage[s] <= stage[s-1];
    end
  end

  assign dout = stage[DEPTH-1];

  // R8
  tap_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !shift |=> $stable(dout));

  // R9
  tap_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shift |=> stage[0] == $past(din));

endmodule

// File: rtl/iir_unf_mac.sv
module iir_unf_mac #(
  parameter int WIDTH = 16,
  parameter int FRAC  = 15
) (
  input  logic signed [WIDTH-1:0] coeff,
  input  logic signed [WIDTH-1:0] fb,
  input  logic signed [WIDTH-1:0] x,
  output logic signed [WIDTH-1:0] y
);

  localparam int PROD_W = 2 * WIDTH;

  logic signed [PROD_W-1:0] prod;

  always_comb begin
    prod = PROD_W'(coeff) * PROD_W'(fb);
    y    = x + WIDTH'(prod >>> FRAC);
  end

endmodule

// File: rtl/iir_unf_top.sv
module iir_unf_top #(
  parameter int LANES      = 2,
  parameter int SAMPLE_W   = 16,
  parameter int FRAC_W     = 15,
  parameter int LOOP_DELAY = 9
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [SAMPLE_W-1:0]       coeff,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [LANES*SAMPLE_W-1:0] in_data,
  output logic                      out_valid,
  input  logic                      out_ready,
  output logic [LANES*SAMPLE_W-1:0] out_data
);
  import iir_unf_pkg::*;

  localparam int BUS_W = LANES * SAMPLE_W;

  logic                accept;
  logic [SAMPLE_W-1:0] lane_y  [LANES];
  logic [SAMPLE_W-1:0] lane_fb [LANES];
  logic [SAMPLE_W-1:0] tap_out [LANES];
  logic [BUS_W-1:0]    y_bus;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  // One history chain per source lane, sized by its unfolded delay.
  for (genvar i = 0; i < LANES; i++) begin : g_tap
    localparam int DEPTH = tap_depth(i, LANES, LOOP_DELAY);
    iir_unf_tap #(.WIDTH(SAMPLE_W), .DEPTH(DEPTH)) u_tap (
      .clk   (clk),
      .rst_n (rst_n),
      .shift (accept),
      .din   (lane_y[i]),
      .dout  (tap_out[i])
    );
  end

  // Each lane reads the chain of the lane that lies nine samples behind it.
  for (genvar j = 0; j < LANES; j++) begin : g_lane
    localparam int SRC = src_lane(j, LANES, LOOP_DELAY);
    assign lane_fb[j] = tap_out[SRC];

    iir_unf_mac #(.WIDTH(SAMPLE_W), .FRAC(FRAC_W)) u_mac (
      .coeff (coeff),
      .fb    (lane_fb[j]),
      .x     (in_data[j*SAMPLE_W +: SAMPLE_W]),
      .y     (lane_y[j])
    );

    assign y_bus[j*SAMPLE_W +: SAMPLE_W] = lane_y[j];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (accept) begin
      out_valid <= 1'b1;
      out_data  <= y_bus;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  // R5
  beat_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  // R5
  drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid && out_ready |=> !out_valid);

  // R7
  no_take_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && in_valid |=> $stable(out_data));

endmodule

// File: tb/iir_unf_top_test.sv
module iir_unf_top_test;
  localparam int J   = 2;
  localparam int W   = 16;
  localparam int BUS = J * W;

  logic           clk = 1'b0;
  logic           rst_n;
  logic [W-1:0]   coeff;
  logic           in_valid;
  logic           in_ready;
  logic [BUS-1:0] in_data;
  logic           out_valid;
  logic           out_ready;
  logic [BUS-1:0] out_data;

  always #5 clk = ~clk;

  iir_unf_top #(.LANES(J)) uut (
    .clk(clk), .rst_n(rst_n), .coeff(coeff),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  logic signed [W-1:0] yref [0:1023];
  int                  nref;
  logic [BUS-1:0]      exp_bus;

  task automatic chk(input string req, input string what, input logic [W-1:0] got,
                     input logic [W-1:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  // Sample-serial reference: one sample per call, in stream order.
  task automatic ref_step(input logic signed [W-1:0] x, output logic [W-1:0] y);
    logic signed [W-1:0]   old;
    logic signed [2*W-1:0] p;
    old = (nref >= 9) ? yref[nref-9] : '0;
    p   = old * $signed(coeff);
    y   = p[30:15] + x;
    yref[nref] = y;
    nref++;
  endtask

  // Lane 0 is the earliest sample of the beat (R2).
  task automatic load_beat(input logic [BUS-1:0] d);
    logic [W-1:0] y;
    for (int l = 0; l < J; l++) begin
      ref_step(d[l*W +: W], y);
      exp_bus[l*W +: W] = y;
    end
    in_data  = d;
    in_valid = 1'b1;
  endtask

  task automatic check_out(input string req);
    chk(req, "out_valid", {15'd0, out_valid}, 16'd1);
    for (int l = 0; l < J; l++)
      chk(req, $sformatf("lane %0d", l), out_data[l*W +: W], exp_bus[l*W +: W]);
  endtask

  function automatic logic [BUS-1:0] rnd_beat();
    logic [BUS-1:0] d;
    for (int l = 0; l < J; l++) d[l*W +: W] = W'($urandom);
    return d;
  endfunction

  task automatic do_reset(input logic [W-1:0] a);
    rst_n = 1'b0; coeff = a; in_valid = 1'b0; in_data = '0; out_ready = 1'b1;
    nref = 0;
    repeat (3) @(negedge clk);
    chk("R1", "out_valid in reset", {15'd0, out_valid}, 16'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "out_valid after reset", {15'd0, out_valid}, 16'd0);
    chk("R7", "in_ready after reset", {15'd0, in_ready}, 16'd1);
  endtask

  task automatic t_lane_order();
    do_reset(16'h0000);
    for (int b = 0; b < 6; b++) begin
      logic [BUS-1:0] d;
      for (int l = 0; l < J; l++) d[l*W +: W] = W'(16'h1000 * b + l + 1);
      load_beat(d);
      @(negedge clk);
      check_out("R2");
    end
    in_valid = 1'b0;
  endtask

  task automatic t_impulse();
    do_reset(16'h4000);
    for (int b = 0; b < 20; b++) begin
      load_beat(b == 0 ? BUS'(16'h4000) : '0);
      @(negedge clk);
      check_out(nref <= 9 ? "R4" : "R3");
    end
    in_valid = 1'b0;
  endtask

  task automatic t_random();
    do_reset(W'($urandom));
    for (int b = 0; b < 60; b++) begin
      load_beat(rnd_beat());
      @(negedge clk);
      check_out(nref <= 9 ? "R4" : "R3");
    end
    in_valid = 1'b0;
  endtask

  task automatic t_wrap();
    do_reset(16'h7FFF);
    for (int b = 0; b < 25; b++) begin
      logic [BUS-1:0] d;
      for (int l = 0; l < J; l++) d[l*W +: W] = (b % 3 == 2) ? 16'h8001 : 16'h7000;
      load_beat(d);
      @(negedge clk);
      check_out("R3");
    end
    in_valid = 1'b0;
  endtask

  task automatic t_bubbles();
    do_reset(16'hC123);
    for (int b = 0; b < 30; b++) begin
      load_beat(rnd_beat());
      @(negedge clk);
      check_out("R8");
      in_valid = 1'b0;
      in_data  = rnd_beat();
      for (int g = 0; g < (b % 3); g++) begin
        @(negedge clk);
        chk("R5", "out_valid in bubble", {15'd0, out_valid}, 16'd0);
      end
    end
    in_valid = 1'b0;
  endtask

  task automatic t_backpressure();
    do_reset(16'h5A5A);
    for (int b = 0; b < 20; b++) begin
      logic [BUS-1:0] held;
      logic [BUS-1:0] nxt;
      load_beat(rnd_beat());
      @(negedge clk);
      check_out("R5");
      if (b % 2 == 1) begin
        held      = exp_bus;
        nxt       = rnd_beat();
        out_ready = 1'b0;
        in_data   = nxt;
        in_valid  = 1'b1;
        for (int s = 0; s < 3; s++) begin
          @(negedge clk);
          chk("R7", "in_ready under stall", {15'd0, in_ready}, 16'd0);
          chk("R6", "out_valid under stall", {15'd0, out_valid}, 16'd1);
          for (int l = 0; l < J; l++)
            chk("R6", $sformatf("held lane %0d", l), out_data[l*W +: W], held[l*W +: W]);
        end
        load_beat(nxt);
        out_ready = 1'b1;
        @(negedge clk);
        check_out("R6");
      end
    end
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; coeff = '0; in_valid = 1'b0; in_data = '0; out_ready = 1'b1;
    @(negedge clk);
    t_lane_order();
    t_impulse();
    t_random();
    t_wrap();
    t_bubbles();
    t_backpressure();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule